// File: doc/BRIEF.md
# Local Clock Gating Buffer

This block models the local clock buffer that sits between a free-running global clock and one bank of scannable master-slave latches. Each cycle it decides whether the bank is clocked at all. A bank is clocked when a functional request or a scan shift asks for it, unless the test-hold override is active. When the bank is clocked, the buffer produces a slave clock pulse in the first half of the cycle. In the second half it produces a pulse on either the functional data-port clock or the scan-port clock.

The decision is made one cycle ahead. Whatever the request inputs show at the end of cycle N gates cycle N+1. The upstream control logic can therefore compute its request from a single register stage. The enable is held in a latch that is transparent while the global clock is low, and it is then ANDed with the clock. A second latch, transparent while the clock is high, carries the decision into the second half of the cycle. Every output pulse is a full half-cycle long, whatever the request inputs do in the middle of a cycle.

The bank is modelled as well, so that the gating can be seen from end to end. A data-port pulse loads the parallel input into the first level. A scan-port pulse shifts the chain by one bit. The slave clock of the next clocked cycle moves the first level to the outputs. Control pins are plain levels, and there is no data handshake.

Top module: `lcb_gate`

## Requirements
- R1: The buffer fires in cycle N+1 exactly when, at the end of cycle N, hold_n is 1 and at least one of the following holds: scan_en is 1, or act_n is 0. act_n and hold_n are active low.
- R2: In a cycle that fires, slave_clk is high for the whole high phase of gclk. slave_clk is low during every low phase and during every high phase of a cycle that does not fire.
- R3: In a cycle that fires, exactly one second-half clock pulses during the low phase of gclk. It is data_clk when scan_en was 0 at the deciding point, and scan_clk when scan_en was 1. Both are low during every high phase and in cycles that do not fire.
- R4: When hold_n was 0 at the deciding point, none of slave_clk, data_clk or scan_clk pulses in the next cycle, whatever act_n and scan_en are.
- R5: Only the request values present at the end of the low phase count. Changes to act_n, scan_en or hold_n during the high phase, or earlier in the low phase, neither shorten nor add a pulse. Each clock gives at most one pulse per cycle.
- R6: A data_clk pulse loads din into the first latch level. The slave_clk pulse of the next cycle that fires moves that value to q.
- R7: A scan_clk pulse loads the first latch level with q shifted up by one bit, with scan_in entering bit 0. The next firing cycle's slave_clk moves this to q. scan_out always equals q[WIDTH-1].
- R8: In a cycle that does not fire, q keeps its value for the whole cycle.
- R9: While rst_n is 0, q and the first latch level are 0, the enable is cleared and no output clock pulses, even when act_n is 0 or scan_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Free-running global clock |
| rst_n | input | 1 | Asynchronous active-low reset of enable and bank |
| act_n | input | 1 | Active-low activation request for the next cycle |
| scan_en | input | 1 | Scan request; it also selects the scan port |
| hold_n | input | 1 | Active-low test-hold override |
| din | input | WIDTH | Functional data for the bank |
| scan_in | input | 1 | Serial scan input into bit 0 |
| slave_clk | output | 1 | First-half slave-level clock |
| data_clk | output | 1 | Second-half functional data-port clock |
| scan_clk | output | 1 | Second-half scan-port clock |
| q | output | WIDTH | Bank outputs (slave level) |
| scan_out | output | 1 | Serial scan output, q[WIDTH-1] |

## Verification
On every cycle, the assertions compare each of the three output clocks with the enable equation registered one cycle earlier. They also check that the second-half clocks are mutually exclusive, that each clock stays inside its own half of the cycle, that test-hold suppresses all three clocks, and that q does not move in a cycle that does not fire.

Some behaviour only the bench scenarios can show. These are the data values moved through the functional and scan ports, and the shift order of the scan chain. They also include the pulse totals that would reveal an extra or split pulse when a request toggles inside a low phase or changes during a high phase. The reset behaviour with requests asserted is shown by the bench as well.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

  // Decision captured for one gated cycle.
  typedef struct packed {
    logic fire;
    logic scan;
  } lcb_en_t;

  // Enable equation: test-hold overrides, otherwise scan or activation fires.
  function automatic lcb_en_t lcb_decode(input logic act_n,
                                         input logic scan_en,
                                         input logic hold_n);
    lcb_en_t r;
    r.fire = hold_n & (scan_en | ~act_n);
    r.scan = scan_en;
    return r;
  endfunction

endpackage

// File: rtl/lcb_arm.sv
// Low-transparent enable latch: the request settles while gclk is low and
// is frozen for the whole high phase that follows.
module lcb_arm
  import lcb_pkg::*;
(
  input  logic    gclk,
  input  logic    rst_n,
  input  logic    act_n,
  input  logic    scan_en,
  input  logic    hold_n,
  output lcb_en_t arm_q
);

  lcb_en_t req;

  always_comb req = lcb_decode(act_n, scan_en, hold_n);

  always_latch begin
    if (!rst_n)
      arm_q <= '0;
    else if (!gclk)
      arm_q <= req;
  end

endmodule

// File: rtl/lcb_phase.sv
// Phase clock generation. The slave clock is gated directly by the
// low-transparent latch. The second-half clocks use a high-transparent copy
// of it, so each AND sees a stable enable over its whole active phase.
module lcb_phase
  import lcb_pkg::*;
(
  input  logic    gclk,
  input  logic    rst_n,
  input  lcb_en_t arm_q,
  output logic    slave_clk,
  output logic    data_clk,
  output logic    scan_clk
);

  lcb_en_t late_q;

  always_latch begin
    if (!rst_n)
      late_q <= '0;
    else if (gclk)
      late_q <= arm_q;
  end

  assign slave_clk = gclk & arm_q.fire;
  assign data_clk  = ~gclk & late_q.fire & ~late_q.scan;
  assign scan_clk  = ~gclk & late_q.fire & late_q.scan;

endmodule

// File: rtl/lcb_cell.sv
// One scannable master-slave bit. Each level is also qualified by the phase
// of gclk, so the two levels are never open in the same delta.
module lcb_cell (
  input  logic gclk,
  input  logic rst_n,
  input  logic slave_clk,
  input  logic data_clk,
  input  logic scan_clk,
  input  logic d,
  input  logic si,
  output logic q
);

  logic lvl1;

  always_latch begin
    if (!rst_n)
      lvl1 <= 1'b0;
    else if (!gclk && data_clk)
      lvl1 <= d;
    else if (!gclk && scan_clk)
      lvl1 <= si;
  end

  always_latch begin
    if (!rst_n)
      q <= 1'b0;
    else if (gclk && slave_clk)
      q <= lvl1;
  end

endmodule

// File: rtl/lcb_bank.sv
// Latch bank driven by the buffer; the scan chain runs from bit 0 upward.
module lcb_bank #(
  parameter int WIDTH = 8
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic             slave_clk,
  input  logic             data_clk,
  input  logic             scan_clk,
  input  logic [WIDTH-1:0] din,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_head
      assign chain[i] = scan_in;
    end else begin : g_link
      assign chain[i] = q[i-1];
    end

    lcb_cell u_cell (
      .gclk      (gclk),
      .rst_n     (rst_n),
      .slave_clk (slave_clk),
      .data_clk  (data_clk),
      .scan_clk  (scan_clk),
      .d         (din[i]),
      .si        (chain[i]),
      .q         (q[i])
    );
  end

endmodule

// File: rtl/lcb_gate.sv
module lcb_gate
  import lcb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic             act_n,
  input  logic             scan_en,
  input  logic             hold_n,
  input  logic [WIDTH-1:0] din,
  input  logic             scan_in,
  output logic             slave_clk,
  output logic             data_clk,
  output logic             scan_clk,
  output logic [WIDTH-1:0] q,
  output logic             scan_out
);

  lcb_en_t arm_q;

  lcb_arm u_arm (
    .gclk    (gclk),
    .rst_n   (rst_n),
    .act_n   (act_n),
    .scan_en (scan_en),
    .hold_n  (hold_n),
    .arm_q   (arm_q)
  );

  lcb_phase u_phase (
    .gclk      (gclk),
    .rst_n     (rst_n),
    .arm_q     (arm_q),
    .slave_clk (slave_clk),
    .data_clk  (data_clk),
    .scan_clk  (scan_clk)
  );

  lcb_bank #(.WIDTH(WIDTH)) u_bank (
    .gclk      (gclk),
    .rst_n     (rst_n),
    .slave_clk (slave_clk),
    .data_clk  (data_clk),
    .scan_clk  (scan_clk),
    .din       (din),
    .scan_in   (scan_in),
    .q         (q)
  );

  assign scan_out = q[WIDTH-1];

endmodule

// File: rtl/lcb_gate_chk.sv
module lcb_gate_chk #(
  parameter int WIDTH = 8
) (
  input logic             gclk,
  input logic             rst_n,
  input logic             act_n,
  input logic             scan_en,
  input logic             hold_n,
  input logic             slave_clk,
  input logic             data_clk,
  input logic             scan_clk,
  input logic [WIDTH-1:0] q
);

  // Request seen at the rising edge, i.e. at the end of the deciding cycle.
  logic want_fire, want_scan, want_hold;

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      want_fire <= 1'b0;
      want_scan <= 1'b0;
      want_hold <= 1'b0;
    end else begin
      want_fire <= hold_n & (scan_en | ~act_n);
      want_scan <= scan_en;
      want_hold <= ~hold_n;
    end
  end

  // Sampled at the falling edge: values of the high phase just ended.
  assert_slave_fire_R1: assert property (@(negedge gclk) disable iff (!rst_n)
    slave_clk == want_fire);

  assert_hold_slave_R4: assert property (@(negedge gclk) disable iff (!rst_n)
    want_hold |-> !slave_clk);

  assert_second_off_high_R3: assert property (@(negedge gclk) disable iff (!rst_n)
    !data_clk && !scan_clk);

  assert_q_stable_R8: assert property (@(negedge gclk) disable iff (!rst_n)
    !want_fire |-> $stable(q));

  // Sampled at the rising edge: values of the low phase just ended.
  assert_slave_off_low_R2: assert property (@(posedge gclk) disable iff (!rst_n)
    !slave_clk);

  assert_data_port_R3: assert property (@(posedge gclk) disable iff (!rst_n)
    data_clk == (want_fire && !want_scan));

  assert_scan_port_R3: assert property (@(posedge gclk) disable iff (!rst_n)
    scan_clk == (want_fire && want_scan));

  assert_port_excl_R3: assert property (@(posedge gclk) disable iff (!rst_n)
    $onehot0({data_clk, scan_clk}));

  assert_hold_second_R4: assert property (@(posedge gclk) disable iff (!rst_n)
    want_hold |-> (!data_clk && !scan_clk));

endmodule

bind lcb_gate lcb_gate_chk #(.WIDTH(WIDTH)) u_chk (
  .gclk      (gclk),
  .rst_n     (rst_n),
  .act_n     (act_n),
  .scan_en   (scan_en),
  .hold_n    (hold_n),
  .slave_clk (slave_clk),
  .data_clk  (data_clk),
  .scan_clk  (scan_clk),
  .q         (q)
);

// File: tb/sim_lcb_gate.sv
`timescale 1ns/1ps
module sim_lcb_gate;
  localparam int W = 8;

  logic gclk = 1'b0;
  logic rst_n, act_n, scan_en, hold_n, scan_in;
  logic [W-1:0] din;
  logic slave_clk, data_clk, scan_clk, scan_out;
  logic [W-1:0] q;

  int n_run = 0, n_fail = 0;
  int n_slave = 0, n_data = 0, n_scan = 0;
  int e_slave = 0, e_data = 0, e_scan = 0;
  bit mon_on = 0;
  bit done = 0;

  typedef struct { bit fire; bit scan; string tag; } exp_t;
  exp_t sb[$];

  logic [W-1:0] m_l1 = '0, m_q = '0;

  always #4 gclk = ~gclk;  // 125 MHz

  lcb_gate #(.WIDTH(W)) u0 (
    .gclk(gclk), .rst_n(rst_n), .act_n(act_n), .scan_en(scan_en),
    .hold_n(hold_n), .din(din), .scan_in(scan_in), .slave_clk(slave_clk),
    .data_clk(data_clk), .scan_clk(scan_clk), .q(q), .scan_out(scan_out)
  );

  always @(posedge slave_clk) n_slave++;
  always @(posedge data_clk)  n_data++;
  always @(posedge scan_clk)  n_scan++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies the request during the high phase of cycle N and pushes
  // what cycle N+1 must do. With wiggle, act_n toggles inside the low phase
  // and returns before the phase ends.
  task automatic step(input bit a_n, input bit sc, input bit h_n,
                      input logic [W-1:0] d, input bit si,
                      input string tag, input bit wiggle = 0);
    exp_t e;
    @(posedge gclk); #2;
    act_n = a_n; scan_en = sc; hold_n = h_n; din = d; scan_in = si;
    e.fire = h_n && (sc || !a_n);
    e.scan = sc;
    e.tag  = tag;
    sb.push_back(e);
    if (wiggle) begin
      @(negedge gclk); #1;
      act_n = ~a_n;
      #1;
      act_n = a_n;
    end
  endtask

  // Monitor: pops one expectation per cycle and compares the phase clocks and
  // bank contents against a model built from the requirements.
  initial begin
    exp_t e;
    wait (mon_on);
    forever begin
      @(posedge gclk); #1;
      if (sb.size() > 0) e = sb.pop_front();
      else begin e.fire = 0; e.scan = 0; e.tag = "R1"; end
      if (e.fire) begin
        m_q = m_l1;
        e_slave++;
      end
      check(slave_clk == e.fire, {e.tag, "/R2 slave_clk early high"}, slave_clk, e.fire);
      #2;
      check(slave_clk == e.fire, {e.tag, "/R5 slave_clk late high"}, slave_clk, e.fire);
      check(q == m_q, {e.tag, "/R6 q after slave phase"}, q, m_q);
      @(negedge gclk); #1;
      check(data_clk == (e.fire && !e.scan), {e.tag, "/R3 data_clk"}, data_clk, e.fire && !e.scan);
      check(scan_clk == (e.fire && e.scan), {e.tag, "/R3 scan_clk"}, scan_clk, e.fire && e.scan);
      check(q == m_q, {e.tag, "/R8 q in low phase"}, q, m_q);
      check(scan_out == m_q[W-1], "R7 scan_out", scan_out, m_q[W-1]);
      if (e.fire) begin
        if (e.scan) begin
          m_l1 = {m_q[W-2:0], scan_in};
          e_scan++;
        end else begin
          m_l1 = din;
          e_data++;
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset with requests asserted: nothing may pulse (R9).
    rst_n = 0; act_n = 0; scan_en = 1; hold_n = 1; din = 8'hFF; scan_in = 1;
    repeat (4) @(posedge gclk);
    #2;
    check(n_slave == 0 && n_data == 0 && n_scan == 0, "R9 no pulses in reset",
          n_slave + n_data + n_scan, 0);
    check(q == 0, "R9 q in reset", q, 0);
    act_n = 1; scan_en = 0; rst_n = 1; mon_on = 1;

    // Idle and the basic functional path.
    step(1, 0, 1, 8'h00, 0, "R1");
    step(0, 0, 1, 8'h11, 0, "R1");
    step(0, 0, 1, 8'hA5, 0, "R6");
    step(1, 0, 1, 8'h3C, 0, "R6");
    step(1, 0, 1, 8'h77, 0, "R8");
    step(0, 0, 1, 8'h5A, 0, "R6");
    step(1, 0, 1, 8'hC3, 0, "R6");
    step(1, 0, 1, 8'h00, 0, "R8");

    // Test-hold overrides activation and scan.
    step(0, 0, 0, 8'hEE, 0, "R4");
    step(0, 1, 0, 8'hDD, 1, "R4");
    step(1, 1, 0, 8'hBB, 1, "R4");
    step(1, 0, 1, 8'h99, 0, "R4");
    step(1, 0, 1, 8'h00, 0, "R8");

    // Scan shift of a walking pattern through the chain.
    for (int i = 0; i < 10; i++)
      step(1, 1, 1, 8'h00, (i % 3) == 0, "R7");
    step(1, 0, 1, 8'h00, 0, "R7");
    step(1, 0, 1, 8'h00, 0, "R8");

    // Scan and activation together pick the scan port.
    step(0, 1, 1, 8'hF0, 1, "R3");
    step(0, 0, 1, 8'h0F, 0, "R3");
    step(1, 0, 1, 8'h00, 0, "R3");

    // Mid-low-phase toggles: only the final value counts (R5).
    step(0, 0, 1, 8'h12, 0, "R5", 1);
    step(1, 0, 1, 8'h34, 0, "R5", 1);
    step(0, 0, 1, 8'h56, 0, "R5", 1);
    step(0, 0, 1, 8'h78, 0, "R5");
    step(1, 0, 1, 8'h9A, 0, "R5");
    step(1, 0, 1, 8'h00, 0, "R8");
    step(1, 0, 1, 8'h00, 0, "R8");

    repeat (3) @(posedge gclk);
    #3;
    check(n_slave == e_slave, "R5 slave pulse total", n_slave, e_slave);
    check(n_data == e_data, "R5 data pulse total", n_data, e_data);
    check(n_scan == e_scan, "R5 scan pulse total", n_scan, e_scan);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule